// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Lines

The block gathers 32 level-sensitive request lines from the rest of the chip and presents them to a processor core in two forms. Most lines form a maskable group. Each of these lines sets a pending bit, and that bit is gated by a software-written mask. The gated result is reduced to one interrupt request wire and a vector number. When exactly one gated request is active, the vector is a fixed base plus that request's bit index. When two or more are active, a single shared "several pending" code is sent instead, and software decides which one to service first. The two highest lines skip the mask altogether and feed a dedicated non-maskable output.

A small synchronous register port gives access to the mask, the raw pending bits, the gated pending bits and the non-maskable status. All status words are kept up to date from the sampled request lines. The vector, request and non-maskable outputs are registered, so each follows a change on the lines or the mask one clock later.

Top module: `intc_vec_nmi`

## Requirements
- R1: While reset is asserted (rst_n low), every register reads zero and vec_o, irq_o and nmi_o are low.
- R2: For 1 <= n <= 29, raw pending bit n-1 (word index 1) follows the level of line n one clock edge after it is sampled. Line 0 changes no register and no output. Raw bits 29 to 31 always read zero.
- R3: A write with we high to any byte address whose word index (address shifted right by two) is 0 stores wdata into the mask register. The mask reads back unchanged at word index 0.
- R4: A write to any word index other than 0 leaves the mask and all outputs unchanged.
- R5: The gated pending word (word index 2) always equals the raw pending word ANDed with the mask.
- R6: One edge after a change on the lines or the mask, vec_o is set from the gated pending bits. It is 0x00 when no bit is set, 0x31 + i when only bit i is set, and 0x30 when two or more bits are set.
- R7: irq_o is high exactly when vec_o is nonzero.
- R8: Non-maskable status (word index 3) bit 30 follows line 30 and bit 31 follows line 31, whatever the mask holds. Bits 0 to 29 always read zero.
- R9: nmi_o is high exactly when some non-maskable status bit is set. It updates on the same edge as the status word.
- R10: rdata is valid in the cycle after the address is presented. Word index 4 and every word index of 5 or above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Level-sensitive request lines |
| addr | input | 8 | Byte address of the register port |
| we | input | 1 | Write strobe for the current address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| vec_o | output | 8 | Vector number for the core |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The properties assume that the request lines and the port signals change only between clock edges. They also assume that we is held low during reset, so that the mask-write properties never look back at a strobe that arrived while the block was held cleared. The bench drives every input on the falling edge and keeps we low whenever rst_n is low. Its patterns include a single line at the lowest maskable index, one at the highest, the ignored line 0 and lines hidden by the mask. These are the cases where the one-hot, several-pending and zero encodings of the vector are told apart.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Word indices of the register port; the bench and software decode them.
  typedef enum logic [2:0] {
    WI_MASK   = 3'd0,
    WI_RAW    = 3'd1,
    WI_GATED  = 3'd2,
    WI_NMI    = 3'd3,
    WI_SPARE  = 3'd4
  } word_idx_e;

  localparam int unsigned DEF_LINES     = 32;
  localparam int unsigned DEF_NMI_FIRST = 30;
  localparam int unsigned DEF_ADDR_W    = 8;
  localparam int unsigned DEF_VEC_W     = 8;
  localparam int unsigned DEF_VEC_BASE  = 32'h31;
  localparam int unsigned DEF_VEC_MULTI = 32'h30;

endpackage

// File: rtl/intc_req_capture.sv
module intc_req_capture #(
  parameter int unsigned NUM_LINES = intc_pkg::DEF_LINES,
  parameter int unsigned NMI_FIRST = intc_pkg::DEF_NMI_FIRST
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_LINES-1:0] raw_next,
  output logic [NUM_LINES-1:0] nmi_next,
  output logic [NUM_LINES-1:0] raw_q,
  output logic [NUM_LINES-1:0] nmi_q
);

  // Line n below NMI_FIRST lands on raw bit n-1; line 0 has no bit.
  function automatic logic [NUM_LINES-1:0] pend_of(input logic [NUM_LINES-1:0] lines);
    logic [NUM_LINES-1:0] r;
    r = '0;
    for (int n = 1; n < NUM_LINES; n++) begin
      if (n < NMI_FIRST) r[n-1] = lines[n];
    end
    return r;
  endfunction

  // Lines at or above NMI_FIRST keep their own bit position.
  function automatic logic [NUM_LINES-1:0] nmi_of(input logic [NUM_LINES-1:0] lines);
    logic [NUM_LINES-1:0] r;
    r = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (n >= NMI_FIRST) r[n] = lines[n];
    end
    return r;
  endfunction

  assign raw_next = pend_of(req_i);
  assign nmi_next = nmi_of(req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      nmi_q <= '0;
    end else begin
      raw_q <= raw_next;
      nmi_q <= nmi_next;
    end
  end

endmodule

// File: rtl/intc_regport.sv
module intc_regport #(
  parameter int unsigned DATA_W = intc_pkg::DEF_LINES,
  parameter int unsigned ADDR_W = intc_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] raw_q,
  input  logic [DATA_W-1:0] nmi_q,
  output logic              mask_wr,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mask_next,
  output logic [DATA_W-1:0] gated_q,
  output logic [DATA_W-1:0] rdata
);
  import intc_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] rd_next;

  function automatic logic [IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return IDX_W'(a >> 2);
  endfunction

  assign word_idx  = word_of(addr);
  assign mask_wr   = we && (word_idx == IDX_W'(WI_MASK));
  assign mask_next = mask_wr ? wdata : mask_q;
  assign gated_q   = raw_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_next;
  end

  always_comb begin
    rd_next = '0;
    if (word_idx == IDX_W'(WI_MASK))       rd_next = mask_q;
    else if (word_idx == IDX_W'(WI_RAW))   rd_next = raw_q;
    else if (word_idx == IDX_W'(WI_GATED)) rd_next = gated_q;
    else if (word_idx == IDX_W'(WI_NMI))   rd_next = nmi_q;
    else                                   rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

endmodule

// File: rtl/intc_vec_out.sv
module intc_vec_out #(
  parameter int unsigned NUM_LINES = intc_pkg::DEF_LINES,
  parameter int unsigned VEC_W     = intc_pkg::DEF_VEC_W,
  parameter int unsigned VEC_BASE  = intc_pkg::DEF_VEC_BASE,
  parameter int unsigned VEC_MULTI = intc_pkg::DEF_VEC_MULTI
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] gated_next,
  input  logic [NUM_LINES-1:0] nmi_next,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 irq_o,
  output logic                 nmi_o
);

  // Only the low NUM_LINES-1 gated bits take part in encoding.
  localparam int unsigned ENC_BITS = NUM_LINES - 1;

  logic [VEC_W-1:0] vec_next;

  function automatic logic [VEC_W-1:0] vec_of(input logic [NUM_LINES-1:0] m);
    logic [VEC_W-1:0] first;
    int unsigned      hits;
    first = '0;
    hits  = 0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (m[i] && (i < ENC_BITS)) begin
        first = VEC_W'(VEC_BASE + i);
        hits  = hits + 1;
      end
    end
    if (hits == 0)      return '0;
    else if (hits == 1) return first;
    else                return VEC_W'(VEC_MULTI);
  endfunction

  assign vec_next = vec_of(gated_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_o <= '0;
      irq_o <= 1'b0;
      nmi_o <= 1'b0;
    end else begin
      vec_o <= vec_next;
      irq_o <= (vec_next != '0);
      nmi_o <= (nmi_next != '0);
    end
  end

endmodule

// File: rtl/intc_vec_nmi.sv
module intc_vec_nmi #(
  parameter int unsigned NUM_LINES = intc_pkg::DEF_LINES,
  parameter int unsigned NMI_FIRST = intc_pkg::DEF_NMI_FIRST,
  parameter int unsigned ADDR_W    = intc_pkg::DEF_ADDR_W,
  parameter int unsigned VEC_W     = intc_pkg::DEF_VEC_W,
  parameter int unsigned VEC_BASE  = intc_pkg::DEF_VEC_BASE,
  parameter int unsigned VEC_MULTI = intc_pkg::DEF_VEC_MULTI
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] rdata,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 irq_o,
  output logic                 nmi_o
);

  // Named internal events, visible to the bound checker.
  logic [NUM_LINES-1:0] raw_next;
  logic [NUM_LINES-1:0] nmi_next;
  logic [NUM_LINES-1:0] raw_q;
  logic [NUM_LINES-1:0] nmi_q;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mask_next;
  logic [NUM_LINES-1:0] gated_q;
  logic [NUM_LINES-1:0] gated_next;
  logic                 mask_wr;

  intc_req_capture #(
    .NUM_LINES (NUM_LINES),
    .NMI_FIRST (NMI_FIRST)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .raw_next (raw_next),
    .nmi_next (nmi_next),
    .raw_q    (raw_q),
    .nmi_q    (nmi_q)
  );

  intc_regport #(
    .DATA_W (NUM_LINES),
    .ADDR_W (ADDR_W)
  ) u_regport (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .we        (we),
    .wdata     (wdata),
    .raw_q     (raw_q),
    .nmi_q     (nmi_q),
    .mask_wr   (mask_wr),
    .mask_q    (mask_q),
    .mask_next (mask_next),
    .gated_q   (gated_q),
    .rdata     (rdata)
  );

  // The outputs are built from next-state values so they move on the same
  // edge as the status words.
  assign gated_next = raw_next & mask_next;

  intc_vec_out #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_MULTI (VEC_MULTI)
  ) u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .gated_next (gated_next),
    .nmi_next   (nmi_next),
    .vec_o      (vec_o),
    .irq_o      (irq_o),
    .nmi_o      (nmi_o)
  );

endmodule

// File: rtl/intc_vec_nmi_chk.sv
module intc_vec_nmi_chk #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned NMI_FIRST = 30,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned VEC_MULTI = 32'h30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 we,
  input logic [NUM_LINES-1:0] wdata,
  input logic                 mask_wr,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] raw_q,
  input logic [NUM_LINES-1:0] nmi_q,
  input logic [NUM_LINES-1:0] gated_q,
  input logic [VEC_W-1:0]     vec_o,
  input logic                 irq_o,
  input logic                 nmi_o
);

  logic other_wr;
  assign other_wr = we && ((addr >> 2) != '0);

  AST_IRQ_FOLLOWS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vec_o != '0)); // R7

  AST_NMI_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o == (nmi_q != '0)); // R9

  AST_MULTI_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o == VEC_W'(VEC_MULTI)) |-> ($countones(gated_q) >= 2)); // R6

  AST_SINGLE_NOT_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gated_q) == 1) |-> (vec_o != VEC_W'(VEC_MULTI) && vec_o != '0)); // R6

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_q == '0) |-> (vec_o == '0)); // R6

  AST_MASK_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wdata))); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> $stable(mask_q)); // R4

  AST_RAW_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q[NUM_LINES-1:NMI_FIRST-1] == '0); // R2

  AST_NMI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q[NMI_FIRST-1:0] == '0); // R8

  AST_GATED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_q & ~(raw_q & mask_q)) == '0); // R5

endmodule

bind intc_vec_nmi intc_vec_nmi_chk #(
  .NUM_LINES (NUM_LINES),
  .NMI_FIRST (NMI_FIRST),
  .ADDR_W    (ADDR_W),
  .VEC_W     (VEC_W),
  .VEC_MULTI (VEC_MULTI)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .we      (we),
  .wdata   (wdata),
  .mask_wr (mask_wr),
  .mask_q  (mask_q),
  .raw_q   (raw_q),
  .nmi_q   (nmi_q),
  .gated_q (gated_q),
  .vec_o   (vec_o),
  .irq_o   (irq_o),
  .nmi_o   (nmi_o)
);

// File: tb/tb_intc_vec_nmi.sv
module tb_intc_vec_nmi;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_i = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  vec_o;
  logic        irq_o;
  logic        nmi_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intc_vec_nmi dut (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .addr  (addr),
    .we    (we),
    .wdata (wdata),
    .rdata (rdata),
    .vec_o (vec_o),
    .irq_o (irq_o),
    .nmi_o (nmi_o)
  );

  // {lines, mask, expected vector}
  localparam logic [71:0] TBL [11] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 8'h00},
    {32'h0000_0002, 32'hFFFF_FFFF, 8'h31},
    {32'h2000_0000, 32'hFFFF_FFFF, 8'h4D},
    {32'h0000_0028, 32'hFFFF_FFFF, 8'h30},
    {32'h0000_0028, 32'h0000_0004, 8'h33},
    {32'h0000_0001, 32'hFFFF_FFFF, 8'h00},
    {32'h4000_0000, 32'hFFFF_FFFF, 8'h00},
    {32'h8000_0002, 32'h0000_0000, 8'h00},
    {32'h0000_0010, 32'h0000_0008, 8'h34},
    {32'h3FFF_FFFE, 32'h1000_0000, 8'h4D},
    {32'hC000_0000, 32'hFFFF_FFFF, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_raw(input logic [31:0] l);
    logic [31:0] r = '0;
    for (int k = 0; k <= 28; k++) r[k] = l[k+1];
    return r;
  endfunction

  function automatic logic [31:0] exp_nmi(input logic [31:0] l);
    return {l[31:30], 30'd0};
  endfunction

  // Present an address at a falling edge; data is read one edge later.
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lines, mask;
    logic [7:0]  ev;
    // R1: outputs and registers cleared in reset
    req_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1 vec in reset", 32'(vec_o), 0);
    chk("R1 irq in reset", 32'(irq_o), 0);
    chk("R1 nmi in reset", 32'(nmi_o), 0);
    chk("R1 rdata in reset", rdata, 0);
    req_i = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 5; w++) begin
      rd(8'(w * 4), d);
      chk("R1 word after reset", d, 0);
    end

    // Table walk: R2 R5 R6 R7 R8 R9
    for (int t = 0; t < 11; t++) begin
      {lines, mask, ev} = TBL[t];
      req_i = lines;
      wr(8'h00, mask);
      chk("R6 vector", 32'(vec_o), 32'(ev));
      chk("R7 irq", 32'(irq_o), 32'(ev != 0));
      chk("R9 nmi", 32'(nmi_o), 32'(lines[31:30] != 0));
      rd(8'h04, d);
      chk("R2 raw word", d, exp_raw(lines));
      rd(8'h08, d);
      chk("R5 gated word", d, exp_raw(lines) & mask);
      rd(8'h0C, d);
      chk("R8 nmi word", d, exp_nmi(lines));
    end

    // R3: readback and low address bits ignored
    wr(8'h03, 32'hA5A5_0F0F);
    rd(8'h00, d);
    chk("R3 mask readback", d, 32'hA5A5_0F0F);

    // R4: writes elsewhere ignored, outputs unchanged
    req_i = 32'h0000_0002;          // raw bit 0, masked off
    wr(8'h00, 32'h0000_0000);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    chk("R4 vec after stray writes", 32'(vec_o), 0);
    chk("R4 irq after stray writes", 32'(irq_o), 0);
    rd(8'h00, d);
    chk("R4 mask after stray writes", d, 0);

    // R10: spare and out-of-range words read zero
    req_i = 32'hFFFF_FFFF;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h10, d);
    chk("R10 word 4", d, 0);
    rd(8'h14, d);
    chk("R10 word 5", d, 0);
    rd(8'hFC, d);
    chk("R10 last word", d, 0);
    // R10: data comes one edge after the address
    addr = 8'h00;
    @(negedge clk);
    addr = 8'h10;
    #1;
    chk("R10 read latency", rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 read latency next", rdata, 0);

    // R6 timing: output moves only at the next edge
    req_i = 32'h0000_0000;
    @(negedge clk);
    req_i = 32'h0000_0040;          // line 6 -> raw bit 5
    #1;
    chk("R6 before edge", 32'(vec_o), 0);
    @(negedge clk);
    chk("R6 after edge", 32'(vec_o), 32'h36);
    // R8: NMI ignores the mask
    wr(8'h00, 32'h0000_0000);
    req_i = 32'h8000_0000;
    @(negedge clk);
    chk("R8 nmi with mask clear", 32'(nmi_o), 1);
    rd(8'h0C, d);
    chk("R8 nmi word masked", d, 32'h8000_0000);

    // R1: reset mid-run clears everything
    req_i = 32'hC000_0006;
    wr(8'h00, 32'hFFFF_FFFF);
    rst_n = 1'b0;
    #1;
    chk("R1 vec mid reset", 32'(vec_o), 0);
    chk("R1 nmi mid reset", 32'(nmi_o), 0);
    @(negedge clk);
    req_i = '0;
    rst_n = 1'b1;
    rd(8'h00, d);
    chk("R1 mask after reset", d, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule